// File: doc/BRIEF.md
# Selectable Word Source with Paced Test Pattern

This block sits in front of the write port of a large buffer FIFO and decides which 32-bit word stream reaches it. A two-bit mode input, which may change at any time and with no relation to the block clock, chooses among four settings. The first passes an external high-speed input channel straight through. The second runs an on-chip pattern generator at a fast paced rate. The third runs the same generator at a quarter of that rate. The fourth is a quiet setting that writes nothing. The block drives the FIFO write data and write enable, and it receives the FIFO full flag as back-pressure.

The generator emits an incrementing count. Once the stream has looped back through the FIFO, a host can check it by confirming that each word is one more than the word before. Words are paced by a clock-enable divider on the block clock. When the FIFO reports full, the word waiting to go out is held and sent later, so the count never skips or repeats. A mode request passes through a two-flop synchronizer. It is applied only when no generator word is waiting, so a switch never cuts a word in half or drops one.

Top module: `stream_source_mux`

## Requirements
- R1: While reset is asserted, and until a synchronized mode code has been applied, wr_en_o and ext_ready_o are 0. The applied mode after reset is the quiet code 11.
- R2: With applied mode 00: wr_en_o = ext_valid_i AND NOT fifo_full_i, wr_data_o = ext_data_i, and ext_ready_o = NOT fifo_full_i.
- R3: With applied mode 01 and the FIFO not full, exactly one word is written every HI_DIV clock cycles.
- R4: With applied mode 10 and the FIFO not full, exactly one word is written every 4*HI_DIV clock cycles.
- R5: With applied mode 11, wr_en_o and ext_ready_o stay 0 whatever ext_valid_i does.
- R6: wr_en_o and ext_ready_o are never 1 while fifo_full_i is 1. A generator word that is waiting during full is kept, not dropped.
- R7: Generator words are consecutive values that start at 0 after reset. The sequence continues across full stalls and across mode changes.
- R8: A change on mode_i becomes the applied mode on the third rising clock edge after it, provided no generator word is waiting. A waiting word is written first, no new generator word is started while a change is requested, and the switch follows on the next edge.
- R9: In modes 01 and 10, ext_ready_o is 0 and external data is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Source select code, asynchronous to clk |
| ext_data_i | input | DW | Word from the external high-speed channel |
| ext_valid_i | input | 1 | External word is present |
| ext_ready_o | output | 1 | External word is taken this cycle when valid |
| fifo_full_i | input | 1 | FIFO full flag (back-pressure) |
| wr_data_o | output | DW | FIFO write data |
| wr_en_o | output | 1 | FIFO write enable |

## Verification
A wrong internal count shows up on the very next generator write, as a word that is not one more than the last. A lost or duplicated waiting word shows up in the first write after full clears. A wrong pacing count or divide selection shows up as a wrong number of writes over a window of sixteen periods. A mode register that switches early, late or in the middle of a word shows up within three cycles: ext_ready_o rises at the wrong time, or the word written after a stall comes from the wrong source.

// File: rtl/srcsel_pkg.sv
package srcsel_pkg;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'b00,
        SRC_FAST = 2'b01,
        SRC_SLOW = 2'b10,
        SRC_RSVD = 2'b11
    } src_mode_e;

endpackage

// File: rtl/srcsel_sync.sv
module srcsel_sync #(
    parameter int             W    = 2,
    parameter logic [W-1:0]   INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage1: INIT, stage2: INIT};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage2;

endmodule

// File: rtl/srcsel_pacer.sv
module srcsel_pacer #(
    parameter int HI_DIV    = 4,
    parameter int SLOW_MULT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic slow_i,
    input  logic restart_i,
    output logic tick_o
);

    localparam int SLOW_DIV = HI_DIV * SLOW_MULT;
    localparam int CW       = $clog2(SLOW_DIV + 1);
    localparam logic [CW-1:0] FAST_LIM = CW'(HI_DIV - 1);
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pace_t;

    pace_t pc_d, pc_q;
    logic [CW-1:0] lim;

    always_comb begin
        pc_d   = pc_q;
        lim    = slow_i ? SLOW_LIM : FAST_LIM;
        tick_o = 1'b0;
        if (restart_i || !run_i) begin
            pc_d.cnt = '0;
        end else if (pc_q.cnt >= lim) begin
            pc_d.cnt = '0;
            tick_o   = 1'b1;
        end else begin
            pc_d.cnt = pc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    generate
        if (HI_DIV >= 2) begin : g_gap_chk
            // R3: enables are never back to back when the divide is two or more
            p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/srcsel_patgen.sv
module srcsel_patgen #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          tick_i,
    input  logic          full_i,
    output logic          pend_o,
    output logic          wr_o,
    output logic [DW-1:0] word_o
);

    typedef struct packed {
        logic          pend;
        logic [DW-1:0] cnt;
    } gen_t;

    gen_t gn_d, gn_q;
    logic wr;

    always_comb begin
        gn_d = gn_q;
        wr   = gn_q.pend && sel_i && !full_i;
        if (wr) begin
            gn_d.cnt = gn_q.cnt + 1'b1;
        end
        if (tick_i) begin
            gn_d.pend = 1'b1;
        end else if (wr) begin
            gn_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gn_q <= '0;
        end else begin
            gn_q <= gn_d;
        end
    end

    assign pend_o = gn_q.pend;
    assign wr_o   = wr;
    assign word_o = gn_q.cnt;

    // R6: a waiting word and its value survive a full cycle
    p_hold_on_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gn_q.pend && full_i) |=> (gn_q.pend && gn_q.cnt == $past(gn_q.cnt)));

    // R7: every write advances the count by exactly one
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> (gn_q.cnt == $past(gn_q.cnt) + 1'b1));

endmodule

// File: rtl/stream_source_mux.sv
module stream_source_mux
    import srcsel_pkg::*;
#(
    parameter int DW        = 32,
    parameter int HI_DIV    = 4,
    parameter int SLOW_MULT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [DW-1:0] ext_data_i,
    input  logic          ext_valid_i,
    output logic          ext_ready_o,
    input  logic          fifo_full_i,
    output logic [DW-1:0] wr_data_o,
    output logic          wr_en_o
);

    localparam int MW = 2;

    typedef struct packed {
        src_mode_e active;
    } ctl_t;

    ctl_t ct_d, ct_q;

    logic [MW-1:0] mode_sync;
    logic          gen_sel, gen_slow, gen_run, restart;
    logic          tick, gen_pend, gen_wr;
    logic [DW-1:0] gen_word;

    srcsel_sync #(.W(MW), .INIT(MW'(SRC_RSVD))) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (mode_i),
        .sync_o  (mode_sync)
    );

    always_comb begin
        ct_d = ct_q;
        if (!gen_pend) begin
            ct_d.active = src_mode_e'(mode_sync);
        end
        restart  = (ct_d.active != ct_q.active);
        gen_sel  = (ct_q.active == SRC_FAST) || (ct_q.active == SRC_SLOW);
        gen_slow = (ct_q.active == SRC_SLOW);
        gen_run  = gen_sel && (src_mode_e'(mode_sync) == ct_q.active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q.active <= SRC_RSVD;
        end else begin
            ct_q <= ct_d;
        end
    end

    srcsel_pacer #(.HI_DIV(HI_DIV), .SLOW_MULT(SLOW_MULT)) u_pacer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (gen_run),
        .slow_i    (gen_slow),
        .restart_i (restart),
        .tick_o    (tick)
    );

    srcsel_patgen #(.DW(DW)) u_patgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (gen_sel),
        .tick_i (tick),
        .full_i (fifo_full_i),
        .pend_o (gen_pend),
        .wr_o   (gen_wr),
        .word_o (gen_word)
    );

    always_comb begin
        wr_en_o     = 1'b0;
        wr_data_o   = '0;
        ext_ready_o = 1'b0;
        unique case (ct_q.active)
            SRC_EXT: begin
                ext_ready_o = !fifo_full_i;
                wr_en_o     = ext_valid_i && !fifo_full_i;
                wr_data_o   = ext_data_i;
            end
            SRC_FAST, SRC_SLOW: begin
                wr_en_o   = gen_wr;
                wr_data_o = gen_word;
            end
            default: begin
                wr_en_o = 1'b0;
            end
        endcase
    end

    // R8: the applied mode only moves when no generator word was waiting
    p_switch_between_words_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.active != $past(ct_q.active)) |-> !$past(gen_pend));

    // R5: the quiet code never writes or accepts
    p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.active == SRC_RSVD) |-> (!wr_en_o && !ext_ready_o));

    // R9: a generator write carries the count, not external data
    p_gen_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_sel && wr_en_o) |-> (wr_data_o == gen_word && !ext_ready_o));

    // R8: no waiting word can be carried into the external or quiet settings
    p_no_stray_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_sel |-> !gen_pend);

endmodule

// File: tb/test_stream_source_mux.sv
module test_stream_source_mux;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int HI_DIV     = 4;
    localparam int SLOW_MULT  = 4;
    localparam int SLOW_DIV   = HI_DIV * SLOW_MULT;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode_i;
    logic [DW-1:0] ext_data_i;
    logic          ext_valid_i;
    logic          ext_ready_o;
    logic          fifo_full_i;
    logic [DW-1:0] wr_data_o;
    logic          wr_en_o;

    stream_source_mux #(.DW(DW), .HI_DIV(HI_DIV), .SLOW_MULT(SLOW_MULT)) i_stream_source_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .ext_data_i  (ext_data_i),
        .ext_valid_i (ext_valid_i),
        .ext_ready_o (ext_ready_o),
        .fifo_full_i (fifo_full_i),
        .wr_data_o   (wr_data_o),
        .wr_en_o     (wr_en_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int            n_vec = 0;
    int            n_bad = 0;
    int            gen_writes = 0;
    int            ext_writes = 0;
    logic [DW-1:0] exp_word = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // write monitor, sampled at the falling edge while inputs are stable
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (fifo_full_i && (wr_en_o || ext_ready_o)) begin
                chk(1'b0, "R6", "write or ready while full", {62'd0, wr_en_o, ext_ready_o}, 64'd0);
            end
            if (wr_en_o && !fifo_full_i) begin
                if (ext_valid_i && ext_ready_o) begin
                    ext_writes++;
                end else begin
                    chk(wr_data_o == exp_word, "R7", "generator word", 64'(wr_data_o), 64'(exp_word));
                    exp_word++;
                    gen_writes++;
                end
            end
        end
    end

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
        logic          full;
        logic          exp_wr;
        logic          exp_rdy;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 1'b1, 1'b0, 1'b1, 1'b1},
        '{32'hCAFE_F00D, 1'b1, 1'b0, 1'b1, 1'b1},
        '{32'h1111_2222, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0BAD_0BAD, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h8000_0000, 1'b1, 1'b0, 1'b1, 1'b1}
    };

    initial begin
        #(CLK_PERIOD * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int base;
        int base_e;
        rst_n       = 1'b0;
        mode_i      = 2'b00;
        ext_data_i  = '0;
        ext_valid_i = 1'b0;
        fifo_full_i = 1'b0;

        // R1: reset state
        step(3);
        chk(!wr_en_o && !ext_ready_o, "R1", "outputs in reset", {62'd0, wr_en_o, ext_ready_o}, 64'd0);
        rst_n = 1'b1;
        #1;
        chk(!ext_ready_o, "R1", "ready right after reset", 64'(ext_ready_o), 64'd0);

        // R8: mode 00 applied on the third edge after release
        step(2);
        chk(!ext_ready_o, "R8", "ready after two edges", 64'(ext_ready_o), 64'd0);
        step(1);
        chk(ext_ready_o, "R8", "ready after three edges", 64'(ext_ready_o), 64'd1);

        // R2: pass-through vectors
        for (int i = 0; i < NV; i++) begin
            ext_data_i  = VECS[i].data;
            ext_valid_i = VECS[i].valid;
            fifo_full_i = VECS[i].full;
            #2;
            chk(wr_en_o == VECS[i].exp_wr, "R2", "pass wr_en", 64'(wr_en_o), 64'(VECS[i].exp_wr));
            chk(ext_ready_o == VECS[i].exp_rdy, "R2", "pass ready", 64'(ext_ready_o), 64'(VECS[i].exp_rdy));
            if (VECS[i].exp_wr) begin
                chk(wr_data_o == VECS[i].data, "R2", "pass data", 64'(wr_data_o), 64'(VECS[i].data));
            end
            step(1);
        end
        ext_valid_i = 1'b0;
        fifo_full_i = 1'b0;

        // R3, R9: fast generator with external data offered
        mode_i = 2'b01;
        step(4 + 2 * HI_DIV);
        ext_valid_i = 1'b1;
        ext_data_i  = 32'hA5A5_5A5A;
        base   = gen_writes;
        base_e = ext_writes;
        step(16 * HI_DIV);
        chk(gen_writes - base == 16, "R3", "fast window writes", 64'(gen_writes - base), 64'd16);
        chk(!ext_ready_o, "R9", "ready in generator mode", 64'(ext_ready_o), 64'd0);
        chk(ext_writes == base_e, "R9", "external writes in generator mode", 64'(ext_writes - base_e), 64'd0);
        ext_valid_i = 1'b0;

        // R6, R7: stall on full and resume with the held word
        fifo_full_i = 1'b1;
        base = gen_writes;
        step(5 * HI_DIV);
        chk(gen_writes == base, "R6", "writes while full", 64'(gen_writes - base), 64'd0);
        fifo_full_i = 1'b0;
        step(3 * HI_DIV);
        chk(gen_writes > base, "R7", "resume after full", 64'(gen_writes - base), 64'd1);

        // R4, R7: slow generator keeps the sequence going
        mode_i = 2'b10;
        step(8 + 2 * SLOW_DIV);
        base = gen_writes;
        step(16 * SLOW_DIV);
        chk(gen_writes - base == 16, "R4", "slow window writes", 64'(gen_writes - base), 64'd16);

        // R5: quiet code
        mode_i = 2'b11;
        step(2 * SLOW_DIV);
        ext_valid_i = 1'b1;
        ext_data_i  = 32'h5555_AAAA;
        base   = gen_writes;
        base_e = ext_writes;
        step(100);
        chk(gen_writes == base && ext_writes == base_e, "R5", "writes in quiet code",
            64'(gen_writes - base + ext_writes - base_e), 64'd0);
        chk(!ext_ready_o && !wr_en_o, "R5", "ready in quiet code", {62'd0, wr_en_o, ext_ready_o}, 64'd0);
        ext_valid_i = 1'b0;

        // R8: waiting word is written before switching to external input
        mode_i = 2'b01;
        step(4 + 2 * HI_DIV);
        fifo_full_i = 1'b1;
        step(2 * HI_DIV);
        ext_valid_i = 1'b1;
        ext_data_i  = 32'h1234_5678;
        mode_i      = 2'b00;
        step(10);
        chk(!ext_ready_o, "R8", "switch held for waiting word", 64'(ext_ready_o), 64'd0);
        base   = gen_writes;
        base_e = ext_writes;
        fifo_full_i = 1'b0;
        step(3);
        chk(gen_writes == base + 1, "R8", "waiting word written once", 64'(gen_writes - base), 64'd1);
        chk(ext_writes > base_e, "R8", "external input applied", 64'(ext_writes - base_e), 64'd1);
        chk(ext_ready_o, "R8", "ready after switch", 64'(ext_ready_o), 64'd1);
        ext_valid_i = 1'b0;
        step(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule